// File: doc/BRIEF.md
# Delta Codec Calibration Pattern Source and Run-of-Three Duty Meter

This block is test equipment for a slope-adaptive delta codec. It has two independent halves. The source half plays one of four fixed calibration bit sequences, one bit per strobe. A rate select picks the short (16 kbit/s) or long (32 kbit/s) family. A level select picks the pattern with no runs of three or the one that should give a 0.30 run-of-three duty.

The meter half watches any bit stream, one bit per strobe, over a window whose length is set at run time. Within the window it tracks the run-of-three flag, which is true for one bit period after three like bits in a row. At the end of each window it reports how many bits raised the flag, together with the window length, so that the duty cycle can be worked out as count over length. The two halves share only clock and reset, so the meter can watch the source's own output or a codec's encoder output.

Top module: `refpat_duty_meter`

## Requirements
- R1: With rate_sel=0 and level_sel=0 the source emits the 20-bit word 0xDB492, most significant bit first, repeating.
- R2: With rate_sel=1 and level_sel=0 the source emits the 40-bit word 0xDB54924AB6, most significant bit first, repeating.
- R3: With rate_sel=0 and level_sel=1 the source emits the 20-bit word 0xFB412, most significant bit first, repeating.
- R4: With rate_sel=1 and level_sel=1 the source emits the 40-bit word 0xFDAA10255E, most significant bit first, repeating.
- R5: Each cycle with gen_en high produces the next pattern bit on gen_bit, with gen_valid high, in the following cycle. After the last bit the pattern continues from its first bit. Without a strobe gen_bit holds its value and gen_valid is low.
- R6: If either select differs from the selection used for the previous strobe, the next strobe emits bit 0 of the newly selected pattern.
- R7: After a meter strobe, r3_flag is 1 exactly when that bit and the two bits before it in the same window are all equal. It holds that value until the next strobe.
- R8: When the number of bits strobed in a window reaches the window length, win_done pulses for one cycle. hit_count then shows the number of flagged bits in that window and win_count shows the window length. Both hold until the next window completes.
- R9: The meter's bit history is cleared at each window start, so no run is counted across a window boundary.
- R10: win_len is sampled at the first bit of each window, and changes made during the window have no effect. A win_len of 0 is treated as 1.
- R11: After reset, gen_bit, gen_valid, r3_flag, win_done, hit_count and win_count are all 0.
- R12: A window aligned with the pattern start and as long as the pattern gives a count of 0 for the two level_sel=0 patterns, 6 of 20 for R3, and 12 of 40 for R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gen_en | input | 1 | Source strobe: one bit per high cycle |
| rate_sel | input | 1 | 0 = 20-bit family, 1 = 40-bit family |
| level_sel | input | 1 | 0 = no-run pattern, 1 = 30 % run pattern |
| gen_bit | output | 1 | Current source bit |
| gen_valid | output | 1 | Pulses in the cycle after a source strobe |
| mtr_en | input | 1 | Meter strobe: mtr_bit is taken in this cycle |
| mtr_bit | input | 1 | Bit under measurement |
| win_len | input | WIN_W | Window length in bits, sampled at window start |
| r3_flag | output | 1 | Run-of-three flag for the last strobed bit |
| win_done | output | 1 | One-cycle pulse at the end of each window |
| hit_count | output | WIN_W | Flagged bits in the last finished window |
| win_count | output | WIN_W | Length of the last finished window |

## Verification
Every result in the block sits one register after the strobe that causes it. gen_bit and gen_valid, r3_flag, and win_done with its count and length all change on the edge that samples the strobe. The bench therefore raises a strobe on a falling edge and drops it on the next falling edge. It reads the outputs at that same falling edge, which is exactly one rising edge later. The idle checks read the outputs again after several more falling edges with no strobe, to show that the values are held and the pulses stay low.

// File: rtl/refpat_pkg.sv
package refpat_pkg;

    localparam int IDX_W     = 6;
    localparam int SHORT_LEN = 20;
    localparam int LONG_LEN  = 40;

    localparam logic [19:0] PAT_SHORT_QUIET = 20'hDB492;
    localparam logic [19:0] PAT_SHORT_BUSY  = 20'hFB412;
    localparam logic [39:0] PAT_LONG_QUIET  = 40'hDB54924AB6;
    localparam logic [39:0] PAT_LONG_BUSY   = 40'hFDAA10255E;

    typedef struct packed {
        logic rate;
        logic level;
    } sel_t;

    function automatic logic [IDX_W-1:0] pat_len(input logic rate);
        return rate ? IDX_W'(LONG_LEN) : IDX_W'(SHORT_LEN);
    endfunction

    function automatic logic pat_bit(input sel_t s, input logic [IDX_W-1:0] idx);
        logic [39:0]      word;
        logic [IDX_W-1:0] shamt;
        case ({s.rate, s.level})
            2'b00:   word = {20'h0, PAT_SHORT_QUIET};
            2'b01:   word = {20'h0, PAT_SHORT_BUSY};
            2'b10:   word = PAT_LONG_QUIET;
            default: word = PAT_LONG_BUSY;
        endcase
        shamt = pat_len(s.rate) - IDX_W'(1) - idx;
        word  = word >> shamt;
        return word[0];
    endfunction

endpackage

// File: rtl/refpat_gen.sv
module refpat_gen
    import refpat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  sel_t sel_i,
    output logic bit_o,
    output logic vld_o
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        sel_t             sel;
        logic             bit_v;
        logic             vld;
    } gen_st_t;

    gen_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (en_i) begin
            st_d.vld = 1'b1;
            if (sel_i != st_q.sel) begin
                st_d.sel   = sel_i;
                st_d.bit_v = pat_bit(sel_i, '0);
                st_d.idx   = IDX_W'(1);
            end else begin
                st_d.bit_v = pat_bit(st_q.sel, st_q.idx);
                st_d.idx   = (st_q.idx == pat_len(st_q.sel.rate) - IDX_W'(1))
                           ? '0 : st_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_o = st_q.bit_v;
    assign vld_o = st_q.vld;

    // R5
    gen_vld_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> $past(en_i));

    // R5
    gen_idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idx < pat_len(st_q.sel.rate));

    // R6
    gen_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (sel_i != st_q.sel)) |=> (st_q.idx == IDX_W'(1)));

    // R5
    gen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(st_q.bit_v));

endmodule

// File: rtl/r3_meter.sv
module r3_meter #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             bit_i,
    input  logic [WIN_W-1:0] win_i,
    output logic             flag_o,
    output logic             done_o,
    output logic [WIN_W-1:0] hits_o,
    output logic [WIN_W-1:0] wlen_o
);

    localparam logic [WIN_W-1:0] ONE = WIN_W'(1);

    typedef struct packed {
        logic [1:0]       hist;
        logic [1:0]       fill;
        logic [WIN_W-1:0] nbits;
        logic [WIN_W-1:0] nhits;
        logic [WIN_W-1:0] win;
        logic             flag;
        logic             done;
        logic [WIN_W-1:0] rep_hits;
        logic [WIN_W-1:0] rep_len;
    } mtr_st_t;

    mtr_st_t st_d, st_q;

    logic             run3;
    logic [WIN_W-1:0] eff_win;
    logic [WIN_W-1:0] hits_nx;
    logic [WIN_W-1:0] bits_nx;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        eff_win   = (st_q.nbits == '0) ? ((win_i == '0) ? ONE : win_i) : st_q.win;
        run3      = (st_q.fill == 2'd2) && (bit_i == st_q.hist[0]) && (bit_i == st_q.hist[1]);
        hits_nx   = st_q.nhits + {{(WIN_W-1){1'b0}}, run3};
        bits_nx   = st_q.nbits + ONE;
        if (en_i) begin
            st_d.win  = eff_win;
            st_d.flag = run3;
            if (bits_nx == eff_win) begin
                st_d.done     = 1'b1;
                st_d.rep_hits = hits_nx;
                st_d.rep_len  = eff_win;
                st_d.nbits    = '0;
                st_d.nhits    = '0;
                st_d.hist     = '0;
                st_d.fill     = '0;
            end else begin
                st_d.nbits = bits_nx;
                st_d.nhits = hits_nx;
                st_d.hist  = {st_q.hist[0], bit_i};
                st_d.fill  = (st_q.fill == 2'd2) ? 2'd2 : st_q.fill + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign done_o = st_q.done;
    assign hits_o = st_q.rep_hits;
    assign wlen_o = st_q.rep_len;

    // R8
    mtr_done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> $past(en_i));

    // R8
    mtr_hits_le_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (st_q.rep_hits <= st_q.rep_len));

    // R7
    mtr_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(st_q.flag));

    // R8
    mtr_report_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.done |-> ($stable(st_q.rep_hits) && $stable(st_q.rep_len)));

    // R9
    mtr_partial_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.nhits <= st_q.nbits);

endmodule

// File: rtl/refpat_duty_meter.sv
module refpat_duty_meter
    import refpat_pkg::*;
#(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic             rate_sel,
    input  logic             level_sel,
    output logic             gen_bit,
    output logic             gen_valid,
    input  logic             mtr_en,
    input  logic             mtr_bit,
    input  logic [WIN_W-1:0] win_len,
    output logic             r3_flag,
    output logic             win_done,
    output logic [WIN_W-1:0] hit_count,
    output logic [WIN_W-1:0] win_count
);

    sel_t sel;
    assign sel = '{rate: rate_sel, level: level_sel};

    refpat_gen u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (gen_en),
        .sel_i (sel),
        .bit_o (gen_bit),
        .vld_o (gen_valid)
    );

    r3_meter #(.WIN_W(WIN_W)) u_mtr (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (mtr_en),
        .bit_i  (mtr_bit),
        .win_i  (win_len),
        .flag_o (r3_flag),
        .done_o (win_done),
        .hits_o (hit_count),
        .wlen_o (win_count)
    );

endmodule

// File: tb/tb_refpat_duty_meter.sv
module tb_refpat_duty_meter;

    localparam int CLK_P = 10;
    localparam int WIN_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             gen_en = 1'b0;
    logic             rate_sel = 1'b0;
    logic             level_sel = 1'b0;
    logic             gen_bit;
    logic             gen_valid;
    logic             mtr_en = 1'b0;
    logic             mtr_bit = 1'b0;
    logic [WIN_W-1:0] win_len = '0;
    logic             r3_flag;
    logic             win_done;
    logic [WIN_W-1:0] hit_count;
    logic [WIN_W-1:0] win_count;

    int checks = 0;
    int fails  = 0;

    always #(CLK_P/2) clk = ~clk;

    refpat_duty_meter #(.WIN_W(WIN_W)) dut (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .rate_sel(rate_sel),
        .level_sel(level_sel), .gen_bit(gen_bit), .gen_valid(gen_valid),
        .mtr_en(mtr_en), .mtr_bit(mtr_bit), .win_len(win_len),
        .r3_flag(r3_flag), .win_done(win_done), .hit_count(hit_count),
        .win_count(win_count)
    );

    function automatic logic exp_bit(input logic r, input logic l, input int i);
        logic [39:0] w;
        int n;
        n = r ? 40 : 20;
        case ({r, l})
            2'b00:   w = {20'h0, 20'hDB492};
            2'b01:   w = {20'h0, 20'hFB412};
            2'b10:   w = 40'hDB54924AB6;
            default: w = 40'hFDAA10255E;
        endcase
        return w[n - 1 - (i % n)];
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic gen_step(output logic b, output logic v);
        @(negedge clk); gen_en = 1'b1;
        @(negedge clk); gen_en = 1'b0;
        b = gen_bit; v = gen_valid;
    endtask

    task automatic mtr_step(input logic b, output logic f, output logic d);
        @(negedge clk); mtr_en = 1'b1; mtr_bit = b;
        @(negedge clk); mtr_en = 1'b0;
        f = r3_flag; d = win_done;
    endtask

    task automatic t_reset;
        check("R11 gen_bit", int'(gen_bit), 0);
        check("R11 gen_valid", int'(gen_valid), 0);
        check("R11 r3_flag", int'(r3_flag), 0);
        check("R11 win_done", int'(win_done), 0);
        check("R11 hit_count", int'(hit_count), 0);
        check("R11 win_count", int'(win_count), 0);
    endtask

    task automatic t_pattern(input logic r, input logic l, input string req);
        logic b, v;
        int n, bad, vbad;
        n = r ? 40 : 20;
        rate_sel = r; level_sel = l;
        bad = 0; vbad = 0;
        for (int i = 0; i < n + 6; i++) begin
            gen_step(b, v);
            if (b != exp_bit(r, l, i)) bad++;
            if (!v) vbad++;
        end
        check({req, " pattern mismatches incl. wrap (R5)"}, bad, 0);
        check("R5 gen_valid after strobe", vbad, 0);
    endtask

    task automatic t_hold;
        logic b, v;
        gen_step(b, v);
        repeat (3) @(negedge clk);
        check("R5 gen_bit held without strobe", int'(gen_bit), int'(b));
        check("R5 gen_valid low without strobe", int'(gen_valid), 0);
    endtask

    task automatic t_restart;
        logic b, v;
        int bad;
        rate_sel = 1'b0; level_sel = 1'b0;
        for (int i = 0; i < 7; i++) gen_step(b, v);
        rate_sel = 1'b0; level_sel = 1'b1;
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            gen_step(b, v);
            if (b != exp_bit(1'b0, 1'b1, i)) bad++;
        end
        check("R6 restart at bit 0 after select change", bad, 0);
    endtask

    task automatic t_flag;
        logic f, d;
        logic [4:0] seq;
        logic [4:0] want;
        int bad;
        seq  = 5'b00001;
        want = 5'b00110;
        win_len = 16'd5;
        bad = 0;
        for (int i = 4; i >= 0; i--) begin
            mtr_step(seq[i], f, d);
            if (i == 2) begin
                repeat (3) @(negedge clk);
                check("R7 flag held between strobes", int'(r3_flag), 1);
            end
            if (f != want[i]) bad++;
        end
        check("R7 flag sequence", bad, 0);
        check("R8 done at window end", int'(d), 1);
        check("R8 count for 00001", int'(hit_count), 2);
        check("R8 window length", int'(win_count), 5);
        @(negedge clk);
        check("R8 done is one cycle", int'(win_done), 0);
    endtask

    task automatic t_boundary;
        logic f, d;
        win_len = 16'd3;
        mtr_step(1'b1, f, d); mtr_step(1'b1, f, d); mtr_step(1'b1, f, d);
        check("R9 first window count", int'(hit_count), 1);
        mtr_step(1'b1, f, d);
        check("R9 no flag across window start", int'(f), 0);
        mtr_step(1'b1, f, d); mtr_step(1'b0, f, d);
        check("R9 second window count", int'(hit_count), 0);
        check("R8 count held until done", int'(d), 1);
    endtask

    task automatic t_winlen;
        logic f, d;
        int dn;
        win_len = 16'd4;
        dn = 0;
        for (int i = 0; i < 4; i++) begin
            mtr_step(1'b0, f, d);
            if (i == 0) win_len = 16'd2;
            if (d) dn++;
            if (i == 1) check("R10 mid-window win_len change ignored", int'(d), 0);
        end
        check("R10 window ends at latched length", int'(win_count), 4);
        check("R10 count with held zeros", int'(hit_count), 2);
        win_len = 16'd0;
        mtr_step(1'b1, f, d);
        check("R10 zero length acts as one", int'(d), 1);
        check("R10 zero length reported as one", int'(win_count), 1);
    endtask

    task automatic t_duty(input logic r, input logic l, input int n, input int exp_hits,
                          input string req);
        logic f, d;
        win_len = WIN_W'(n);
        for (int i = 0; i < n; i++) mtr_step(exp_bit(r, l, i), f, d);
        check({req, " done"}, int'(d), 1);
        check({req, " run-of-three count"}, int'(hit_count), exp_hits);
        check({req, " window length"}, int'(win_count), n);
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_pattern(1'b0, 1'b0, "R1");
        t_pattern(1'b1, 1'b0, "R2");
        t_pattern(1'b0, 1'b1, "R3");
        t_pattern(1'b1, 1'b1, "R4");
        t_hold();
        t_restart();
        t_flag();
        t_boundary();
        t_winlen();
        t_duty(1'b0, 1'b0, 20, 0,  "R12 short quiet");
        t_duty(1'b1, 1'b0, 40, 0,  "R12 long quiet");
        t_duty(1'b0, 1'b1, 20, 6,  "R12 short busy");
        t_duty(1'b1, 1'b1, 40, 12, "R12 long busy");
        t_duty(1'b1, 1'b1, 100, 30, "R12 long busy 100-bit");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule